// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives a 16x oversampling strobe for a serial transmitter and receiver from the system clock. The divisor is the system clock frequency over sixteen times the baud rate. It is held as an integer part and a 6-bit fraction, where the fraction is the fractional remainder times 64, rounded by adding one half. For example, a 20 MHz clock at 115200 baud gives an integer part of 10 and a fraction of 54. On every tick, a 6-bit accumulator adds the fraction. When that addition carries out, the following tick period is one clock longer. Over time the mean period is therefore the integer part plus the fraction over 64.

Software programs the block through a small write port. The required order is: clear the enable bit, write the integer divisor, write the fraction, then set the enable bit. Writes to the divisor registers take effect only while the block is inactive. The neighbouring transmitter and receiver drive a busy input. If the enable bit is cleared while they are busy, the block keeps ticking until the frame in flight completes, and only then stops.

A three-state controller sequences the block:
- OFF: counter and accumulator are held at zero and there are no ticks.
- RUN: ticks are generated.
- DRAIN: the enable bit has been cleared during a frame, and ticks continue.

The transitions are:
- OFF→RUN when the enable bit is set.
- RUN→OFF when the enable bit is clear and busy is low.
- RUN→DRAIN when the enable bit is clear and busy is high.
- DRAIN→OFF when busy falls.
- DRAIN→RUN when the enable bit is set again.

Top module: `baud16_gen`

## Requirements
- R1: After reset, `baud16_tick` and `active` are 0, the enable bit is clear and both divisors are 0.
- R2: A write with `wr_en` high stores the integer divisor from `wr_data[15:0]` at address 0x024, and the fraction from `wr_data[5:0]` at address 0x028. At address 0x030, `wr_data[0]` is the enable bit (1 = enabled). Writes to any other address change nothing.
- R3: With integer divisor N ≥ 1 and fraction 0, `baud16_tick` is a one-clock pulse that repeats every N clocks.
- R4: On each tick the fraction is added into a 6-bit accumulator that starts at 0. If the sum reaches 64, the next tick period is N+1 clocks; otherwise it is N clocks.
- R5: Over any 64 consecutive periods that begin from the reset accumulator value, the total length is 64·N + fraction clocks.
- R6: While the integer divisor is 0, no tick is produced.
- R7: Writes to the divisor addresses while `active` is 1 are ignored; the tick pattern continues unchanged.
- R8: `active` rises on the second clock edge after the enable bit is written to 1. If the enable bit is cleared while `busy` is 0, `active` falls and ticks stop. The counter and accumulator return to 0, so a later enable restarts the pattern from an accumulator of 0.
- R9: If the enable bit is cleared while `busy` is 1, `active` stays 1 and ticks continue until `busy` falls; then `active` falls and ticks stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 16 | Register write data |
| busy | input | 1 | Transmitter or receiver has a frame in flight |
| baud16_tick | output | 1 | 16x oversampling strobe, one clock wide |
| active | output | 1 | Block is generating ticks (RUN or DRAIN) |

## Verification
The bench measures the gap between consecutive ticks. It compares each gap against an accumulator model, so a design that stretches the wrong period, or never stretches, shows an off-by-one gap. Sixty-four gaps are summed to catch an accumulator of the wrong width, and an integer divisor of 1 with fraction 63 probes the shortest periods. Divisor writes are issued mid-run, where a design that accepted them would shift the gap pattern. The bench re-enables after a disable, where a design that kept its accumulator would start out of phase. It also drops the enable bit during a busy frame, where a design that stopped at once would lose `active` and ticks before `busy` falls.

// File: rtl/baud16_pkg.sv
package baud16_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } gen_state_t;

    localparam int unsigned OFS_IDIV = 32'h024;
    localparam int unsigned OFS_FDIV = 32'h028;
    localparam int unsigned OFS_CTRL = 32'h030;

endpackage

// File: rtl/baud16_regs.sv
module baud16_regs #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              active,
    output logic [INT_W-1:0]  idiv,
    output logic [FRAC_W-1:0] fdiv,
    output logic              en_bit
);
    import baud16_pkg::*;

    logic hit_idiv, hit_fdiv, hit_ctrl;

    always_comb begin
        hit_idiv = wr_en && (wr_addr == ADDR_W'(OFS_IDIV));
        hit_fdiv = wr_en && (wr_addr == ADDR_W'(OFS_FDIV));
        hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idiv   <= '0;
            fdiv   <= '0;
            en_bit <= 1'b0;
        end else begin
            if (hit_idiv && !active) idiv <= wr_data[INT_W-1:0];
            if (hit_fdiv && !active) fdiv <= wr_data[FRAC_W-1:0];
            if (hit_ctrl)            en_bit <= wr_data[0];
        end
    end

    assert_div_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> ($stable(idiv) && $stable(fdiv)));

endmodule

// File: rtl/baud16_fsm.sv
module baud16_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic en_bit,
    input  logic busy,
    output logic active
);
    import baud16_pkg::*;

    gen_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en_bit) state_d = ST_RUN;
            ST_RUN:   if (!en_bit) state_d = busy ? ST_DRAIN : ST_OFF;
            ST_DRAIN: begin
                if (en_bit)     state_d = ST_RUN;
                else if (!busy) state_d = ST_OFF;
            end
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        active = (state_q != ST_OFF);
    end

    assert_drain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !en_bit && busy) |=> active);

    assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && en_bit) |=> active);

endmodule

// File: rtl/baud16_counter.sv
module baud16_counter #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [INT_W-1:0]  idiv,
    input  logic [FRAC_W-1:0] fdiv,
    output logic              tick
);
    localparam int CW = INT_W + 1;

    logic [CW-1:0]     cnt;
    logic [CW-1:0]     lim;
    logic [FRAC_W-1:0] acc;
    logic              stretch;
    logic [FRAC_W:0]   sum;
    logic              div_ok;

    always_comb begin
        div_ok = (idiv != '0);
        lim    = CW'(idiv) - CW'(1) + CW'(stretch);
        sum    = {1'b0, acc} + {1'b0, fdiv};
        tick   = run && div_ok && (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
        end else if (!div_ok) begin
            cnt     <= '0;
        end else if (tick) begin
            cnt     <= '0;
            acc     <= sum[FRAC_W-1:0];
            stretch <= sum[FRAC_W];
        end else begin
            cnt     <= cnt + CW'(1);
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div_ok) |-> (cnt <= CW'(idiv)));

    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && acc == '0 && !stretch));

endmodule

// File: rtl/baud16_gen.sv
module baud16_gen #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              baud16_tick,
    output logic              active
);
    logic [INT_W-1:0]  idiv;
    logic [FRAC_W-1:0] fdiv;
    logic              en_bit;

    baud16_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .active(active), .idiv(idiv), .fdiv(fdiv),
        .en_bit(en_bit)
    );

    baud16_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_bit(en_bit), .busy(busy),
        .active(active)
    );

    baud16_counter #(
        .INT_W(INT_W), .FRAC_W(FRAC_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(active), .idiv(idiv), .fdiv(fdiv),
        .tick(baud16_tick)
    );

    assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !baud16_tick);

    assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idiv == '0) |-> !baud16_tick);

endmodule

// File: tb/tb_baud16_gen.sv
`timescale 1ns/1ps
module tb_baud16_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        baud16_tick;
    logic        active;

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    bit mon_on = 0;
    bit have_last = 0;
    int cyc = 0;
    int last_cyc = 0;
    int tick_cnt = 0;
    int gap_sum = 0;

    always #4 clk = ~clk;

    baud16_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .baud16_tick(baud16_tick),
        .active(active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (baud16_tick) begin
            tick_cnt++;
            if (mon_on) begin
                if (have_last && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    gap_sum += cyc - last_cyc;
                    check((cyc - last_cyc) == e, "R4 tick gap", cyc - last_cyc, e);
                end
                last_cyc  = cyc;
                have_last = 1;
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic push_model(input int n, input int f, input int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) begin
            int s;
            s = acc + f;
            exp_q.push_back(n + (s >= 64 ? 1 : 0));
            acc = s % 64;
        end
    endtask

    task automatic start_mon();
        have_last = 0; gap_sum = 0; mon_on = 1;
    endtask

    task automatic drain_mon(input string tag);
        int w;
        w = 0;
        while (exp_q.size() > 0 && w < 20000) begin
            @(posedge clk); w++;
        end
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
        mon_on = 0;
    endtask

    task automatic disable_now();
        wr(12'h030, 16'h0000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(active == 1'b0, "R8 active low after disable", active, 0);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_up();
    end

    initial begin
        int t0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(baud16_tick == 1'b0, "R1 tick after reset", baud16_tick, 0);
        check(active == 1'b0, "R1 active after reset", active, 0);

        // R1 and R2: enable with divisors still at their reset value of 0 -> silent
        wr(12'h02C, 16'h00FF); // unrelated address, no effect
        t0 = tick_cnt;
        wr(12'h030, 16'h0001);
        repeat (100) @(posedge clk);
        check(tick_cnt == t0, "R1 divisors zero after reset", tick_cnt - t0, 0);
        disable_now();

        // R3 exact period, R2 offsets
        wr(12'h024, 16'd4);
        wr(12'h028, 16'd0);
        push_model(4, 0, 10);
        start_mon();
        wr(12'h030, 16'h0001);
        @(negedge clk);
        check(active == 1'b0, "R8 active one edge after enable", active, 0);
        @(negedge clk);
        check(active == 1'b1, "R8 active two edges after enable", active, 1);
        drain_mon("R3 period N=4");
        disable_now();

        // R4 fractional stretch, R7 ignored writes mid-run
        wr(12'h024, 16'd10);
        wr(12'h028, 16'd54);
        push_model(10, 54, 40);
        start_mon();
        wr(12'h030, 16'h0001);
        repeat (150) @(posedge clk);
        wr(12'h024, 16'd3);
        wr(12'h028, 16'd0);
        drain_mon("R7 pattern unchanged by writes");
        disable_now();
        t0 = tick_cnt;
        repeat (100) @(posedge clk);
        check(tick_cnt == t0, "R8 no ticks when off", tick_cnt - t0, 0);

        // R8 restart from zero accumulator, old divisors kept (R7)
        push_model(10, 54, 20);
        start_mon();
        wr(12'h030, 16'h0001);
        drain_mon("R8 restart pattern");

        // R9 deferred disable
        @(posedge clk); #1 busy = 1'b1;
        wr(12'h030, 16'h0000);
        t0 = tick_cnt;
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(active == 1'b1, "R9 active held while busy", active, 1);
        check(tick_cnt > t0, "R9 ticks continue while busy", tick_cnt - t0, 5);
        @(posedge clk); #1 busy = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(active == 1'b0, "R9 active falls after busy", active, 0);
        t0 = tick_cnt;
        repeat (80) @(posedge clk);
        check(tick_cnt == t0, "R9 silent after drain", tick_cnt - t0, 0);

        // R5 average over 64 periods
        wr(12'h024, 16'd7);
        wr(12'h028, 16'd37);
        push_model(7, 37, 64);
        start_mon();
        wr(12'h030, 16'h0001);
        drain_mon("R5 gaps consumed");
        check(gap_sum == 64 * 7 + 37, "R5 sum of 64 gaps", gap_sum, 64 * 7 + 37);
        disable_now();

        // R4 shortest periods: N=1, F=63
        wr(12'h024, 16'd1);
        wr(12'h028, 16'd63);
        push_model(1, 63, 20);
        start_mon();
        wr(12'h030, 16'h0001);
        drain_mon("R4 N=1 F=63");
        disable_now();

        // R6 integer divisor zero
        wr(12'h024, 16'd0);
        wr(12'h028, 16'd20);
        wr(12'h030, 16'h0001);
        t0 = tick_cnt;
        repeat (300) @(posedge clk);
        check(tick_cnt == t0, "R6 no ticks with zero divisor", tick_cnt - t0, 0);
        disable_now();

        finish_up();
    end
endmodule